// File: doc/BRIEF.md
# Clock-Failure Monitor with Fast-RC Fallback

This block checks that the selected system clock is still running by comparing it with a slow, always-running low-power reference oscillator. The reference domain sends a request toggle across to the monitored clock domain. The monitored domain echoes it back, and the reference domain counts how long each round trip takes. If no round trip completes within a set number of reference periods, the system clock is taken to have stopped. The block then raises a one-cycle clock-failure trap, sets a sticky failure flag, and tells the clock-switching logic to force the system clock over to the fast internal RC oscillator.

When the failure occurs, the block captures the PLL-in-use flag. If the PLL was driving the system clock, the fallback source becomes the fast RC through the PLL with the same multiplier. The monitor runs only when its configuration enable is set. While it is enabled, it asks for the reference oscillator to stay on at all times except during sleep. Checking is suspended during sleep and for a settle window after each wake, enable or new clock switch. After a failure, the block does not re-arm until software starts a new clock switch. Starting that switch also clears the failure flag and releases the override.

The `mon_en`, `sleep_i`, `pll_in_use` and `switch_start` inputs are taken as synchronous to the reference clock. `rst_n` is asserted asynchronously and released synchronously in each clock domain.

Top module: `clkfail_monitor`

## Requirements
- R1: While reset is asserted and directly after it is released, `fail_trap`, `fail_flag`, `force_frc` and `force_pll` are all 0.
- R2: `ref_osc_req` is 1 exactly when `mon_en` is 1 and `sleep_i` is 0. This holds regardless of any watchdog setting.
- R3: While the monitored clock keeps running, with its period much shorter than a reference period, no trap is raised and `fail_flag` stays 0.
- R4: If the monitored clock stops while monitoring is active, `fail_flag` rises within MISS_LIMIT-1 to MISS_LIMIT+5 reference cycles of the stop (default MISS_LIMIT = 5).
- R5: `fail_trap` is a single reference-cycle pulse, given once per failure event. After a failure, no further trap is raised and `fail_flag` stays 1 until `switch_start` is pulsed or `mon_en` drops.
- R6: While `fail_flag` is 1, `force_frc` is 1. `force_pll` equals the value that `pll_in_use` had in the cycle the failure was declared, and it ignores later changes of `pll_in_use`.
- R7: A one-cycle `switch_start` clears `fail_flag`, `force_frc` and `force_pll` at the next reference edge. Monitoring then restarts through the settle window, so a clock that is still stopped trips again.
- R8: No failure is declared while `sleep_i` is 1. After `sleep_i` falls with the monitored clock stopped, `fail_flag` stays 0 for exactly SETTLE_CYCLES+MISS_LIMIT reference cycles and is 1 in the next one (default 4+5, so 1 at the 10th sample).
- R9: With `mon_en` at 0, the flag and override are cleared at the next edge and no trap is raised. Re-enabling with a stopped clock trips after the same SETTLE_CYCLES+MISS_LIMIT+1 reference cycles as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Low-power reference oscillator clock |
| mon_clk | input | 1 | Monitored system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Configuration enable, shared with clock switching |
| sleep_i | input | 1 | Device is in sleep |
| pll_in_use | input | 1 | Current system clock runs through the PLL |
| switch_start | input | 1 | One-cycle pulse: a new valid clock switch starts |
| ref_osc_req | output | 1 | Keep the reference oscillator running |
| fail_trap | output | 1 | One-cycle clock-failure trap event |
| fail_flag | output | 1 | Sticky clock-failure status |
| force_frc | output | 1 | Override: force the system clock to the fast RC |
| force_pll | output | 1 | Override: route the fast RC through the PLL |

## Verification
The assertions check the following on every reference cycle:
- that the trap lasts a single cycle and always comes with the flag and the override;
- that the flag holds until a switch start or a disable;
- that sleep and disable block any trap;
- that the PLL choice in the override matches the flag sampled at the failure.

Only the bench scenarios can show the rest. These are the detection latency after the clock is stopped at several phases, the exact length of the settle window after a wake or re-enable, the absence of false trips while the clock is running, and re-tripping after a switch onto a still-dead clock.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SETTLE = 3'd1,
    ST_WATCH  = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_TRIP   = 3'd4
  } cfm_state_e;
endpackage

// File: rtl/clkfail_rst_sync.sv
module clkfail_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkfail_activity.sv
// Round-trip toggle handshake. A request toggle goes from the reference
// domain into the monitored domain and comes back. alive_o pulses in the
// reference domain each time the echo matches the request. The echo can
// only move when the monitored clock is running, so the result does not
// depend on the ratio between the two clock frequencies.
module clkfail_activity #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic mon_clk,
  input  logic mon_rst_n,
  output logic alive_o
);
  logic                   req_q, req_d;
  logic [SYNC_STAGES-1:0] mon_sync_q;
  logic [SYNC_STAGES-1:0] ref_sync_q;
  logic                   echo_s;

  // monitored domain: bring the request in, its last stage is the echo
  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) mon_sync_q <= '0;
    else            mon_sync_q <= {mon_sync_q[SYNC_STAGES-2:0], req_q};
  end

  // reference domain: bring the echo back
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) ref_sync_q <= '0;
    else            ref_sync_q <= {ref_sync_q[SYNC_STAGES-2:0], mon_sync_q[SYNC_STAGES-1]};
  end

  assign echo_s  = ref_sync_q[SYNC_STAGES-1];
  assign alive_o = (echo_s == req_q);

  always_comb begin
    req_d = req_q;
    if (alive_o) req_d = ~req_q;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) req_q <= 1'b0;
    else            req_q <= req_d;
  end
endmodule

// File: rtl/clkfail_window.sv
// Reference-cycle counters: the settle window and the missed-activity limit.
module clkfail_window #(
  parameter int MISS_LIMIT    = 5,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic settle_en,
  input  logic watch_en,
  input  logic alive,
  output logic settle_done,
  output logic miss_hit
);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [MW-1:0] MISS_LAST   = MW'(MISS_LIMIT - 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

  logic [MW-1:0] miss_q, miss_d;
  logic [SW-1:0] set_q, set_d;

  assign miss_hit    = watch_en && !alive && (miss_q == MISS_LAST);
  assign settle_done = settle_en && (set_q == SETTLE_LAST);

  always_comb begin
    miss_d = miss_q;
    if (!watch_en || alive)       miss_d = '0;
    else if (miss_q != MISS_LAST) miss_d = miss_q + 1'b1;
  end

  always_comb begin
    set_d = set_q;
    if (!settle_en)               set_d = '0;
    else if (set_q != SETTLE_LAST) set_d = set_q + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      miss_q <= '0;
      set_q  <= '0;
    end else begin
      miss_q <= miss_d;
      set_q  <= set_d;
    end
  end
endmodule

// File: rtl/clkfail_ctrl.sv
module clkfail_ctrl
  import clkfail_pkg::*;
(
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic mon_en,
  input  logic sleep_i,
  input  logic pll_in_use,
  input  logic switch_start,
  input  logic settle_done,
  input  logic miss_hit,
  output logic settle_en,
  output logic watch_en,
  output logic trap_o,
  output logic tripped_o,
  output logic pll_o
);
  cfm_state_e st_q, st_d;
  logic       trap_q, trap_d;
  logic       pll_q, pll_d;
  logic       entering_trip;

  always_comb begin
    st_d = st_q;
    if (!mon_en) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:    st_d = sleep_i ? ST_SLEEP : ST_SETTLE;
        ST_SETTLE: begin
          if (sleep_i)          st_d = ST_SLEEP;
          else if (settle_done) st_d = ST_WATCH;
        end
        ST_WATCH: begin
          if (sleep_i)           st_d = ST_SLEEP;
          else if (switch_start) st_d = ST_SETTLE;
          else if (miss_hit)     st_d = ST_TRIP;
        end
        ST_SLEEP:  if (!sleep_i) st_d = ST_SETTLE;
        ST_TRIP:   if (switch_start) st_d = sleep_i ? ST_SLEEP : ST_SETTLE;
        default:   st_d = ST_OFF;
      endcase
    end
  end

  assign entering_trip = (st_d == ST_TRIP) && (st_q != ST_TRIP);

  always_comb begin
    trap_d = entering_trip;
    pll_d  = pll_q;
    if (entering_trip)        pll_d = pll_in_use;
    else if (st_d != ST_TRIP) pll_d = 1'b0;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      st_q   <= ST_OFF;
      trap_q <= 1'b0;
      pll_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      trap_q <= trap_d;
      pll_q  <= pll_d;
    end
  end

  assign settle_en = (st_q == ST_SETTLE);
  assign watch_en  = (st_q == ST_WATCH);
  assign tripped_o = (st_q == ST_TRIP);
  assign trap_o    = trap_q;
  assign pll_o     = pll_q;
endmodule

// File: rtl/clkfail_monitor.sv
module clkfail_monitor #(
  parameter int MISS_LIMIT    = 5,
  parameter int SETTLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic ref_clk,
  input  logic mon_clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic sleep_i,
  input  logic pll_in_use,
  input  logic switch_start,
  output logic ref_osc_req,
  output logic fail_trap,
  output logic fail_flag,
  output logic force_frc,
  output logic force_pll
);
  logic ref_rst_n, mon_rst_n;
  logic alive, settle_en, watch_en, settle_done, miss_hit;
  logic tripped, pll_sel;

  clkfail_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_ref (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));
  clkfail_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_mon (
    .clk(mon_clk), .arst_n(rst_n), .srst_n(mon_rst_n));

  clkfail_activity #(.SYNC_STAGES(SYNC_STAGES)) u_act (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .mon_clk(mon_clk), .mon_rst_n(mon_rst_n),
    .alive_o(alive));

  clkfail_window #(.MISS_LIMIT(MISS_LIMIT), .SETTLE_CYCLES(SETTLE_CYCLES)) u_win (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .settle_en(settle_en), .watch_en(watch_en), .alive(alive),
    .settle_done(settle_done), .miss_hit(miss_hit));

  clkfail_ctrl u_ctrl (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .mon_en(mon_en), .sleep_i(sleep_i), .pll_in_use(pll_in_use),
    .switch_start(switch_start), .settle_done(settle_done), .miss_hit(miss_hit),
    .settle_en(settle_en), .watch_en(watch_en),
    .trap_o(fail_trap), .tripped_o(tripped), .pll_o(pll_sel));

  // reference oscillator stays on whenever the monitor is enabled and awake
  assign ref_osc_req = mon_en && !sleep_i;
  assign fail_flag   = tripped;
  assign force_frc   = tripped;
  assign force_pll   = tripped && pll_sel;
endmodule

// File: rtl/clkfail_monitor_chk.sv
module clkfail_monitor_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic mon_en,
  input logic sleep_i,
  input logic pll_in_use,
  input logic switch_start,
  input logic fail_trap,
  input logic fail_flag,
  input logic force_frc,
  input logic force_pll
);
  p_trap_single_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_trap |=> !fail_trap);

  p_trap_with_flag_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_trap |-> (fail_flag && force_frc));

  p_flag_holds_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_flag && mon_en && !switch_start) |=> (fail_flag && !fail_trap));

  p_switch_clears_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_flag && mon_en && switch_start) |=> (!fail_flag && !force_frc && !force_pll));

  p_sleep_no_trap_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sleep_i |=> !fail_trap);

  p_disable_clears_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mon_en |=> (!fail_flag && !fail_trap && !force_frc));

  p_pll_captured_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fail_flag) |-> (force_pll == $past(pll_in_use)));

  p_pll_needs_force_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    force_pll |-> force_frc);
endmodule

bind clkfail_monitor clkfail_monitor_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .mon_en(mon_en), .sleep_i(sleep_i),
  .pll_in_use(pll_in_use), .switch_start(switch_start), .fail_trap(fail_trap),
  .fail_flag(fail_flag), .force_frc(force_frc), .force_pll(force_pll));

// File: tb/tb_clkfail_monitor.sv
`timescale 1ns/1ps
module tb_clkfail_monitor;
  localparam int MISS   = 5;
  localparam int SETTLE = 4;
  localparam int WD_MAX = 150000;

  logic clk = 1'b0;
  logic ref_clk = 1'b0;
  logic mon_run = 1'b1;
  logic mon_clk;
  logic rst_n = 1'b0;
  logic mon_en = 1'b1, sleep_i = 1'b0, pll_in_use = 1'b0, switch_start = 1'b0;
  logic ref_osc_req, fail_trap, fail_flag, force_frc, force_pll;

  int tests = 0, fails = 0, trap_cnt = 0, wd = 0;

  always #5  clk = ~clk;      // 100 MHz monitored clock source
  always #35 ref_clk = ~ref_clk;
  assign mon_clk = clk & mon_run;

  clkfail_monitor #(.MISS_LIMIT(MISS), .SETTLE_CYCLES(SETTLE)) dut (
    .ref_clk(ref_clk), .mon_clk(mon_clk), .rst_n(rst_n), .mon_en(mon_en),
    .sleep_i(sleep_i), .pll_in_use(pll_in_use), .switch_start(switch_start),
    .ref_osc_req(ref_osc_req), .fail_trap(fail_trap), .fail_flag(fail_flag),
    .force_frc(force_frc), .force_pll(force_pll));

  always @(posedge ref_clk) if (rst_n && fail_trap) trap_cnt++;

  always @(posedge clk) begin
    wd++;
    if (wd >= WD_MAX) begin
      fails++;
      $display("FAIL watchdog expired: act=%0d exp<%0d cycles", wd, WD_MAX);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(string req, int act, int lo, int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: act=%0d exp=[%0d..%0d]", req, act, lo, hi);
    end
  endtask

  task automatic ref_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic stop_mon(int phase);
    for (int i = 0; i < phase; i++) @(negedge clk);
    @(negedge clk) mon_run = 1'b0;
  endtask

  task automatic start_mon();
    @(negedge clk) mon_run = 1'b1;
  endtask

  task automatic pulse_switch();
    @(negedge ref_clk) switch_start = 1'b1;
    @(negedge ref_clk) switch_start = 1'b0;
  endtask

  // samples taken until fail_flag is seen (returns limit+1 if never)
  task automatic wait_flag(int limit, output int lat);
    lat = limit + 1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge ref_clk);
      if (fail_flag) begin lat = k; break; end
    end
  endtask

  initial begin
    int lat, t0;
    // R1 during reset, R2 with enable and awake
    ref_cycles(3);
    check("R1 flag in reset", fail_flag, 0);
    check("R1 trap in reset", fail_trap, 0);
    check("R1 force in reset", int'(force_frc) + int'(force_pll), 0);
    check("R2 osc req enabled awake", ref_osc_req, 1);
    rst_n = 1'b1;
    ref_cycles(1);
    check("R1 flag after release", fail_flag, 0);
    ref_cycles(25);
    check("R3 no trap after start", trap_cnt, 0);
    check("R3 flag low running", fail_flag, 0);

    // R3..R7 sweep over PLL use and stop phase
    for (int p = 0; p < 2; p++) begin
      for (int ph = 0; ph < 4; ph++) begin
        @(negedge ref_clk) pll_in_use = p[0];
        t0 = trap_cnt;
        ref_cycles(15);
        check("R3 running clock no trap", trap_cnt - t0, 0);
        stop_mon(ph * 3);
        wait_flag(MISS + 8, lat);
        check_range("R4 detection latency", lat, MISS - 1, MISS + 5);
        ref_cycles(2);
        check("R5 one trap per event", trap_cnt - t0, 1);
        check("R6 force_frc set", force_frc, 1);
        check("R6 force_pll captured", force_pll, p);
        @(negedge ref_clk) pll_in_use = ~p[0];
        ref_cycles(20);
        check("R5 no re-arm while dead", trap_cnt - t0, 1);
        check("R5 flag sticky", fail_flag, 1);
        check("R6 force_pll ignores later pll", force_pll, p);
        start_mon();
        pulse_switch();
        check("R7 switch clears flag", fail_flag, 0);
        check("R7 switch clears force", int'(force_frc) + int'(force_pll), 0);
        ref_cycles(30);
        check("R7 clean after switch", trap_cnt - t0, 1);
      end
    end

    // R7: switch onto a still-dead clock re-arms and trips again
    t0 = trap_cnt;
    stop_mon(0);
    wait_flag(MISS + 8, lat);
    check("R7 first trip before switch", fail_flag, 1);
    pulse_switch();
    check("R7 cleared on dead clock", fail_flag, 0);
    wait_flag(SETTLE + MISS + 8, lat);
    check("R7 re-trip after switch", lat, SETTLE + MISS);
    ref_cycles(2);
    check("R7 second trap counted", trap_cnt - t0, 2);
    start_mon();
    pulse_switch();
    ref_cycles(20);

    // R8: sleep suspends monitoring, settle window after wake
    t0 = trap_cnt;
    @(negedge ref_clk) sleep_i = 1'b1;
    ref_cycles(1);
    check("R2 osc req off in sleep", ref_osc_req, 0);
    stop_mon(0);
    ref_cycles(30);
    check("R8 no trap in sleep", trap_cnt - t0, 0);
    check("R8 flag low in sleep", fail_flag, 0);
    @(negedge ref_clk) sleep_i = 1'b0;
    wait_flag(SETTLE + MISS + 8, lat);
    check("R8 settle then trip sample", lat, SETTLE + MISS + 1);
    ref_cycles(2);
    check("R8 single trap after wake", trap_cnt - t0, 1);

    // R9: disable clears and blocks; re-enable goes through settle
    @(negedge ref_clk) mon_en = 1'b0;
    ref_cycles(1);
    check("R9 disable clears flag", fail_flag, 0);
    check("R9 disable clears force", force_frc, 0);
    check("R2 osc req off when disabled", ref_osc_req, 0);
    t0 = trap_cnt;
    ref_cycles(30);
    check("R9 no trap while disabled", trap_cnt - t0, 0);
    @(negedge ref_clk) mon_en = 1'b1;
    wait_flag(SETTLE + MISS + 8, lat);
    check("R9 re-enable settle then trip", lat, SETTLE + MISS + 1);
    start_mon();
    pulse_switch();
    ref_cycles(20);
    check("R3 final clean run", fail_flag, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule